// File: doc/BRIEF.md
# Data Map Address Translator

This block turns a logical data-space address into a physical address. A request carries a logical byte offset and a requested byte count. The block returns a physical address, the number of bytes that may be moved in one piece, and a fault flag. It uses a small bank of 16-bit map words. The logical data space is cut into equal blocks, with one map word per block. The map word either sends its block to one of three physical regions at a chosen segment, or switches the block into I/O mode. In I/O mode, a 4-bit page number picked out of the map word by address bits selects a 64 KiB I/O page inside the data region.

Software or a controller loads the map words through a one-word write port. Requests may arrive on every cycle, and each result appears exactly one clock after its request. A two-state controller tracks whether the output registers hold a fresh result. In `ST_IDLE` no result is being presented. The transition `req_accept` (a request is present) moves to `ST_DONE`, where `rsp_valid` is high. From `ST_DONE`, `req_chain` (another request) stays in `ST_DONE` and `req_none` (no request) returns to `ST_IDLE`. `req_none` in `ST_IDLE` stays there.

Top module: `dmx_translator`

## Requirements
- R1: After reset every map word is zero and `rsp_valid`, `rsp_addr`, `rsp_len` and `rsp_fault` are zero. A request with all map words zero is therefore sent to the unified region at segment 0.
- R2: A request sampled on a clock edge produces `rsp_valid` high with its result after that same edge. `rsp_valid` is low after any edge on which `req_valid` was low.
- R3: The map word used is the logical offset divided by 0x4000, taken from offset bits [15:14]. The in-block offset is offset bits [13:0].
- R4: A logical offset of 0x10000 or more (four blocks of 0x4000) gives `rsp_fault`=1, `rsp_len`=0 and `rsp_addr`=0.
- R5: When the in-block offset plus the requested count exceeds 0x4000, the granted count is 0x4000 minus the in-block offset. Otherwise it equals the requested count, including a request that ends exactly at the block end.
- R6: Map bit 15 set selects I/O mode. The page index is (in-block offset / 0x1000) mod 4. The page number is map bits [4*(3-index)+3 : 4*(3-index)]. The address is 0x02000000 + page*0x10000 + 0xC000 + in-block offset.
- R7: With bit 15 clear, map bits [13:12] select the space and bits [9:0] give the segment. Space 0 gives 0x00000000 + segment*0x4000 + in-block offset.
- R8: Space 1 gives 0x01000000 + segment*0x4000 + in-block offset.
- R9: Space 2 gives 0x02000000 + (segment << 16) + map index*0x4000 + in-block offset.
- R10: Space 3 with bit 15 clear gives `rsp_fault`=1, `rsp_len`=0 and `rsp_addr`=0.
- R11: With `map_we` high, `map_wdata` is written into map word `map_sel` on the clock edge. A request sampled on that same edge still uses the old word, and later requests use the new one.
- R12: In I/O mode the space field is ignored, so bits [13:12] = 3 with bit 15 set do not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_off | input | 24 | Logical data offset |
| req_len | input | 16 | Requested byte count |
| map_we | input | 1 | Map word write enable |
| map_sel | input | 2 | Map word index to write |
| map_wdata | input | 16 | Map word write data |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 32 | Physical address, region code in bits [31:24] |
| rsp_len | output | 16 | Granted byte count |
| rsp_fault | output | 1 | Offset out of range or reserved space |

## Verification
On every cycle the assertions check that the response follows the request strobe one cycle later. They also check that a faulting result carries zero address and zero count, that the granted count never exceeds the request, and that no granted piece crosses a block end. Out-of-range offsets are checked to fault on the next cycle. The exact addresses of each space, the I/O page selection, the segment and index arithmetic, and the ordering of a map write against a request on the same edge depend on map contents. Only the bench scenarios show these, by comparing results against an independent model.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    // Controller states of the response register
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } dmx_state_e;

    // Physical space selected by a map word outside I/O mode
    typedef enum logic [1:0] {
        SP_UNIFIED = 2'd0,
        SP_INSN    = 2'd1,
        SP_DATA    = 2'd2,
        SP_RSVD    = 2'd3
    } dmx_space_e;

    // Field positions inside a map word; the decoder depends on them
    localparam int IO_FLAG_BIT = 15;
    localparam int SPACE_LO    = 12;
    localparam int SEG_W       = 10;
    localparam int NIB_W       = 4;
    localparam int NIB_N       = 4;
    localparam int NIB_SEL_W   = 2;

    // Address shifts for I/O page choice and data segments
    localparam int IO_SLICE_SH = 12;
    localparam int PAGE_SH     = 16;

    typedef struct packed {
        logic               io_mode;
        dmx_space_e         space;
        logic [SEG_W-1:0]   seg;
    } map_fields_t;

    function automatic map_fields_t split_map(input logic [15:0] w);
        map_fields_t f;
        f.io_mode = w[IO_FLAG_BIT];
        f.space   = dmx_space_e'(w[SPACE_LO +: 2]);
        f.seg     = w[SEG_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/dmx_map_bank.sv
module dmx_map_bank #(
    parameter int MAP_N = 4,
    parameter int MAP_W = 16,
    localparam int IDX_W = (MAP_N > 1) ? $clog2(MAP_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wsel,
    input  logic [MAP_W-1:0] wdata,
    input  logic [IDX_W-1:0] rsel,
    output logic [MAP_W-1:0] rdata
);

    logic [MAP_W-1:0] words [MAP_N];

    // One register per map word; a write lands on the edge, so a
    // request on that same edge reads the previous content.
    for (genvar g = 0; g < MAP_N; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (we && (wsel == IDX_W'(g))) begin
                words[g] <= wdata;
            end
        end
    end

    assign rdata = words[rsel];

endmodule

// File: rtl/dmx_len_clip.sv
module dmx_len_clip #(
    parameter int LEN_W = 16,
    parameter int BLK_W = 14
) (
    input  logic [BLK_W-1:0] inblk,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] grant_len
);

    localparam logic [LEN_W:0] BLOCK = (LEN_W+1)'(1) << BLK_W;

    logic [LEN_W:0] ext_off;
    logic [LEN_W:0] end_pos;
    logic [LEN_W:0] room;

    always_comb begin
        ext_off = (LEN_W+1)'(inblk);
        end_pos = ext_off + {1'b0, req_len};
        room    = BLOCK - ext_off;
        if (end_pos > BLOCK) begin
            grant_len = room[LEN_W-1:0];
        end else begin
            grant_len = req_len;
        end
    end

endmodule

// File: rtl/dmx_space_decode.sv
module dmx_space_decode
    import dmx_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          BLK_W    = 14,
    parameter int          IDX_W    = 2,
    parameter logic [31:0] UNI_BASE = 32'h0000_0000,
    parameter logic [31:0] INS_BASE = 32'h0100_0000,
    parameter logic [31:0] DAT_BASE = 32'h0200_0000,
    parameter logic [31:0] IO_WIN   = 32'h0000_C000
) (
    input  logic [15:0]       map_word,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BLK_W-1:0]  inblk,
    output logic [ADDR_W-1:0] phys,
    output logic              bad_space
);

    map_fields_t          fld;
    logic [ADDR_W-1:0]    off_x;
    logic [ADDR_W-1:0]    seg_x;
    logic [ADDR_W-1:0]    idx_x;
    logic [ADDR_W-1:0]    slice;
    logic [NIB_SEL_W-1:0] nib_sel;
    logic [NIB_W-1:0]     page;

    always_comb begin
        fld     = split_map(map_word);
        off_x   = ADDR_W'(inblk);
        seg_x   = ADDR_W'(fld.seg);
        idx_x   = ADDR_W'(idx);
        // page slot = (in-block offset / 0x1000) mod 4
        slice   = off_x >> IO_SLICE_SH;
        nib_sel = slice[NIB_SEL_W-1:0];
        page    = map_word[(NIB_N - 1 - int'(nib_sel)) * NIB_W +: NIB_W];
    end

    always_comb begin
        phys      = '0;
        bad_space = 1'b0;
        if (fld.io_mode) begin
            phys = ADDR_W'(DAT_BASE) + (ADDR_W'(page) << PAGE_SH)
                 + ADDR_W'(IO_WIN) + off_x;
        end else begin
            unique case (fld.space)
                SP_UNIFIED: phys = ADDR_W'(UNI_BASE) + (seg_x << BLK_W) + off_x;
                SP_INSN:    phys = ADDR_W'(INS_BASE) + (seg_x << BLK_W) + off_x;
                SP_DATA:    phys = ADDR_W'(DAT_BASE) + (seg_x << PAGE_SH)
                                 + (idx_x << BLK_W) + off_x;
                SP_RSVD:    bad_space = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/dmx_translator.sv
module dmx_translator
    import dmx_pkg::*;
#(
    parameter int OFF_W  = 24,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 14,
    parameter int MAP_N  = 4,
    parameter int MAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              map_we,
    input  logic [1:0]        map_sel,
    input  logic [MAP_W-1:0]  map_wdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LEN_W-1:0]  rsp_len,
    output logic              rsp_fault
);

    localparam int IDX_W = (MAP_N > 1) ? $clog2(MAP_N) : 1;
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(MAP_N) << BLK_W;

    // Request split
    logic              out_of_range;
    logic [IDX_W-1:0]  idx;
    logic [BLK_W-1:0]  inblk;
    logic [MAP_W-1:0]  map_word;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_bad;
    logic [LEN_W-1:0]  clip_len;
    logic              any_fault;

    assign out_of_range = ({1'b0, req_off} >= LIMIT);
    assign idx          = req_off[BLK_W +: IDX_W];
    assign inblk        = req_off[BLK_W-1:0];

    dmx_map_bank #(
        .MAP_N (MAP_N),
        .MAP_W (MAP_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .wsel  (IDX_W'(map_sel)),
        .wdata (map_wdata),
        .rsel  (idx),
        .rdata (map_word)
    );

    dmx_space_decode #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W),
        .IDX_W  (IDX_W)
    ) u_dec (
        .map_word  (map_word),
        .idx       (idx),
        .inblk     (inblk),
        .phys      (dec_addr),
        .bad_space (dec_bad)
    );

    dmx_len_clip #(
        .LEN_W (LEN_W),
        .BLK_W (BLK_W)
    ) u_clip (
        .inblk     (inblk),
        .req_len   (req_len),
        .grant_len (clip_len)
    );

    assign any_fault = out_of_range | dec_bad;

    // Controller: state register, next-state logic, output registers
    dmx_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_DONE : ST_IDLE;   // req_accept / req_none
            ST_DONE: st_d = req_valid ? ST_DONE : ST_IDLE;   // req_chain / req_none
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_addr  <= '0;
            rsp_len   <= '0;
            rsp_fault <= 1'b0;
        end else if (req_valid) begin
            rsp_fault <= any_fault;
            rsp_addr  <= any_fault ? '0 : dec_addr;
            rsp_len   <= any_fault ? '0 : clip_len;
        end
    end

    assign rsp_valid = (st_q == ST_DONE);

endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
    parameter int OFF_W  = 24,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 14,
    parameter int MAP_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OFF_W-1:0]  req_off,
    input logic [LEN_W-1:0]  req_len,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [LEN_W-1:0]  rsp_len,
    input logic              rsp_fault
);

    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(MAP_N) << BLK_W;
    localparam logic [LEN_W:0] BLOCK = (LEN_W+1)'(1) << BLK_W;

    // R2: response follows the request by one cycle
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: no response without a request
    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: out-of-range offsets fault with nothing granted
    assert_range_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_off} >= LIMIT)) |=> (rsp_fault && rsp_len == '0));

    // R10: a fault always carries zero address and zero count
    assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_len == '0 && rsp_addr == '0));

    // R5: never grant more than was asked
    assert_grant_le_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_len <= $past(req_len)));

    // R5: a granted piece never runs past its block end
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
            (((LEN_W+1)'(rsp_addr[BLK_W-1:0]) + {1'b0, rsp_len}) <= BLOCK));

endmodule

bind dmx_translator dmx_checker #(
    .OFF_W  (OFF_W),
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W),
    .MAP_N  (MAP_N)
) u_chk (.*);

// File: tb/sim_dmx_translator.sv
module sim_dmx_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_off = '0;
    logic [15:0] req_len = '0;
    logic        map_we = 1'b0;
    logic [1:0]  map_sel = '0;
    logic [15:0] map_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [15:0] rsp_len;
    logic        rsp_fault;

    int total = 0;
    int bad   = 0;
    logic [15:0] mdl [4];

    always #10 clk = ~clk;   // 50 MHz

    dmx_translator u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_off(req_off),
        .req_len(req_len), .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_len(rsp_len), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Independent model of the translation rules
    function automatic void exp_calc(input logic [23:0] off, input logic [15:0] len,
                                     output logic [31:0] a, output logic [15:0] l, output logic f);
        int unsigned ib, ix, m, seg, sp, nsel, pg, gl;
        a = 0; l = 0; f = 1;
        if (off >= 24'h010000) return;
        ix = off / 32'h4000;
        ib = off % 32'h4000;
        m  = mdl[ix];
        gl = (ib + len > 32'h4000) ? (32'h4000 - ib) : len;
        seg = m & 32'h3FF;
        sp  = (m >> 12) & 3;
        if (m & 32'h8000) begin
            nsel = (ib / 32'h1000) % 4;
            pg   = (m >> (4 * (3 - nsel))) & 32'hF;
            a = 32'h0200_0000 + pg * 32'h10000 + 32'hC000 + ib;
            l = gl[15:0]; f = 0;
        end else if (sp == 3) begin
            return;
        end else begin
            if (sp == 0) a = seg * 32'h4000 + ib;
            else if (sp == 1) a = 32'h0100_0000 + seg * 32'h4000 + ib;
            else a = 32'h0200_0000 + (seg << 16) + ix * 32'h4000 + ib;
            l = gl[15:0]; f = 0;
        end
    endfunction

    task automatic wr_map(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        map_we = 1'b1; map_sel = s; map_wdata = d;
        @(negedge clk);
        map_we = 1'b0;
        mdl[s] = d;
    endtask

    task automatic req_chk(input logic [23:0] off, input logic [15:0] len, input string tag);
        logic [31:0] ea; logic [15:0] el; logic ef;
        exp_calc(off, len, ea, el, ef);
        @(negedge clk);
        req_valid = 1'b1; req_off = off; req_len = len;
        @(posedge clk); #2;
        chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(tag, "addr", rsp_addr, ea);
        chk(tag, "len", 32'(rsp_len), 32'(el));
        chk(tag, "fault", 32'(rsp_fault), 32'(ef));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ea; logic [15:0] el; logic ef;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "rsp_addr", rsp_addr, 0);
        chk("R1", "rsp_len", 32'(rsp_len), 0);
        chk("R1", "rsp_fault", 32'(rsp_fault), 0);
        rst_n = 1'b1;
        req_chk(24'h000123, 16'd4, "R1");
        req_chk(24'h008010, 16'd2, "R1");
        chk("R1", "addr direct", rsp_addr, 32'h0000_0010);
        // R2: idle cycle drops rsp_valid
        @(posedge clk); #2;
        chk("R2", "idle rsp_valid", 32'(rsp_valid), 0);
        // R3 / R8: map 1 to instruction space, segment 5
        wr_map(2'd1, 16'h1005);
        req_chk(24'h004100, 16'd8, "R3");
        chk("R8", "insn addr", rsp_addr, 32'h0101_4100);
        // R4: out of range
        req_chk(24'h010000, 16'd4, "R4");
        req_chk(24'hFFFFFF, 16'd4, "R4");
        // R5: clipping at block end
        req_chk(24'h003FFC, 16'd8, "R5");
        chk("R5", "clipped", 32'(rsp_len), 4);
        req_chk(24'h003FFC, 16'd4, "R5");
        req_chk(24'h000000, 16'hFFFF, "R5");
        req_chk(24'h002000, 16'd0, "R5");
        // R6: I/O mode page select
        wr_map(2'd2, 16'h9ABC);
        req_chk(24'h00A010, 16'd2, "R6");
        chk("R6", "io addr", rsp_addr, 32'h020B_E010);
        req_chk(24'h008000, 16'd2, "R6");
        req_chk(24'h00B500, 16'd2, "R6");
        // R7: unified segment 3
        wr_map(2'd0, 16'h0003);
        req_chk(24'h000020, 16'd16, "R7");
        chk("R7", "uni addr", rsp_addr, 32'h0000_C020);
        // R9: data space segment 7 through map 3
        wr_map(2'd3, 16'h2007);
        req_chk(24'h00C040, 16'd16, "R9");
        chk("R9", "data addr", rsp_addr, 32'h0207_C040);
        // R10: reserved space
        wr_map(2'd3, 16'h3001);
        req_chk(24'h00C040, 16'd16, "R10");
        // R12: I/O mode ignores space field
        wr_map(2'd3, 16'hB123);
        req_chk(24'h00F000, 16'd4, "R12");
        chk("R12", "io addr", rsp_addr, 32'h0203_F000);
        // R11: write and request on the same edge
        exp_calc(24'h000040, 16'd4, ea, el, ef);
        @(negedge clk);
        map_we = 1'b1; map_sel = 2'd0; map_wdata = 16'h1002;
        req_valid = 1'b1; req_off = 24'h000040; req_len = 16'd4;
        @(posedge clk); #2;
        chk("R11", "old word used", rsp_addr, ea);
        @(negedge clk);
        map_we = 1'b0; req_valid = 1'b0;
        mdl[0] = 16'h1002;
        req_chk(24'h000040, 16'd4, "R11");
        chk("R11", "new word used", rsp_addr, 32'h0100_8040);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 4) == 0) wr_map(2'($urandom % 4), 16'($urandom));
            req_chk(24'($urandom % 32'h12000),
                    (($urandom % 2) == 0) ? 16'($urandom % 64) : 16'($urandom),
                    "R3");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule